// File: doc/BRIEF.md
# Interval timer and interrupt register block

This block is a bank of sixteen byte-wide registers on a small processor's memory bus. It holds two general-purpose data registers with their direction registers, a shift register, two control registers, two 16-bit down-counting timers with reload latches, and an interrupt flag and enable pair that drives one active-high interrupt line. The processor selects the block with a chip select, picks a register with four address bits, and either writes a byte or strobes a read.

Some timer byte accesses do more than move data. Writing a timer's high byte starts the counter from the latch and acknowledges that timer's interrupt. Reading a timer's low counter byte also acknowledges it. The enable register is written in set/clear style: bit 7 of the written byte chooses the operation. Timer 1 can run once per start or reload itself on every underflow. Timer 2 always runs once per start.

Top module: `irqt_regblk`

## Requirements
- R1: Offsets 0, 2, 3, 10, 11 and 12 are plain byte registers that read back what was last written. Offsets 1 and 15 both reach the same second data register.
- R2: After reset, offsets 0, 1, 2, 3, 11, 12 and 13 read 0x00, offset 14 reads 0x80, and `irq` is low.
- R3: A write to offset 4 or 6 changes only the low byte of the timer 1 latch. A write to offset 7 changes only its high byte and does not load the counter. Offsets 6 and 7 read the latch low and high bytes.
- R4: A write to offset 5 stores the latch high byte, loads the timer 1 counter with the full latch on that same edge, and clears flag bit 6. Offsets 4 and 5 read the counter low and high bytes. A qualified read of offset 4 clears flag bit 6.
- R5: Each counter decrements by one on every clock. A timer 1 started with value N sets flag bit 6 on the (N+1)th edge after the loading edge, when it steps from 0. It then wraps to 0xFFFF and keeps counting. With bit 6 of offset 11 at 0, this happens only once per load.
- R6: With bit 6 of offset 11 at 1, timer 1 reloads from its latch on each underflow instead of wrapping. It sets flag bit 6 every N+1 cycles.
- R7: A write to offset 8 sets the timer 2 latch low byte. A write to offset 9 sets the high byte, loads the counter, and clears flag bit 5. Offsets 8 and 9 read the counter bytes. A qualified read of offset 8 clears flag bit 5. Underflow sets flag bit 5 once per load, and the counter keeps decrementing through 0xFFFF.
- R8: Offset 13 reads the flags in bits 6:0. Bit 7 is 1 whenever any flag bit is set together with its enable bit. Writing offset 13 clears each flag bit written as 1.
- R9: A write to offset 14 with bit 7 = 1 sets the enable bits given by 1s in bits 6:0. With bit 7 = 0 it clears them. Bits written as 0 are left alone. A read of offset 14 always has bit 7 = 1.
- R10: `irq` is high exactly when some flag bit and its enable bit are both 1.
- R11: Read side effects happen only when `cs` and `rd` are both high. A read strobe without chip select leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select; qualifies reads and writes |
| addr | input | 4 | Register offset |
| we | input | 1 | Write enable |
| wdata | input | 8 | Write data |
| rd | input | 1 | Read strobe; triggers read side effects |
| rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Active-high interrupt request |

## Verification
The bench builds the block with its default 8-bit data width, which gives 16-bit timers and a 7-bit flag and enable pair. This width makes every enable pattern reachable: all 128 patterns are swept in set mode and in clear mode, and again against a fixed pair of raised flags. Starting the timers from small values puts each underflow edge within a few cycles. Each intermediate count, the exact edge on which a flag appears, the wrap to 0xFFFF and three free-running periods are therefore all checked against arithmetic done in the bench.

// File: rtl/irqt_pkg.sv
`timescale 1ns/1ps
package irqt_pkg;
  localparam int REG_AW = 4;

  typedef enum logic [REG_AW-1:0] {
    OFS_PB   = 4'd0,
    OFS_PA   = 4'd1,
    OFS_DDRB = 4'd2,
    OFS_DDRA = 4'd3,
    OFS_T1CL = 4'd4,
    OFS_T1CH = 4'd5,
    OFS_T1LL = 4'd6,
    OFS_T1LH = 4'd7,
    OFS_T2CL = 4'd8,
    OFS_T2CH = 4'd9,
    OFS_SHF  = 4'd10,
    OFS_AUX  = 4'd11,
    OFS_PER  = 4'd12,
    OFS_FLG  = 4'd13,
    OFS_ENA  = 4'd14,
    OFS_PA2  = 4'd15
  } ofs_e;

  localparam int FLG_T1   = 6;
  localparam int FLG_T2   = 5;
  localparam int AUX_FREE = 6;
endpackage

// File: rtl/irqt_timer.sv
`timescale 1ns/1ps
module irqt_timer #(
  parameter int DW             = 8,
  parameter bit RELOAD_CAPABLE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              wr_start,
  input  logic [DW-1:0]     wdata,
  input  logic              free_run,
  output logic [2*DW-1:0]   count,
  output logic [2*DW-1:0]   latch,
  output logic              expire
);
  localparam int TW = 2*DW;
  localparam logic [TW-1:0] ONE = {{(TW-1){1'b0}}, 1'b1};

  logic armed;
  logic reload;
  logic wrap;

  generate
    if (RELOAD_CAPABLE) begin : g_reload
      assign reload = free_run;
    end else begin : g_oneshot
      logic unused_free;
      assign unused_free = free_run;
      assign reload      = 1'b0;
    end
  endgenerate

  function automatic logic [TW-1:0] step(input logic [TW-1:0] cur,
                                         input logic [TW-1:0] lat,
                                         input logic          rl);
    if (cur == '0 && rl) return lat;
    return cur - ONE;
  endfunction

  assign wrap   = (count == '0) && !wr_start;
  assign expire = wrap && (armed || reload);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      latch <= '0;
      armed <= 1'b0;
    end else begin
      if (wr_lo) latch[DW-1:0] <= wdata;
      if (wr_hi || wr_start) latch[TW-1:DW] <= wdata;
      if (wr_start) begin
        count <= {wdata, latch[DW-1:0]};
        armed <= 1'b1;
      end else begin
        count <= step(count, latch, reload);
        if (wrap) armed <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irqt_irqctl.sv
`timescale 1ns/1ps
module irqt_irqctl #(
  parameter int FW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] set_bits,
  input  logic [FW-1:0] clr_bits,
  input  logic          ena_wr,
  input  logic [FW:0]   ena_wdata,
  output logic [FW-1:0] flags,
  output logic [FW-1:0] ena,
  output logic          irq_any
);
  function automatic logic [FW-1:0] ena_next(input logic [FW-1:0] old,
                                             input logic [FW:0]   wv);
    if (wv[FW]) return old | wv[FW-1:0];
    return old & ~wv[FW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
      ena   <= '0;
    end else begin
      flags <= (flags & ~clr_bits) | set_bits;
      if (ena_wr) ena <= ena_next(ena, ena_wdata);
    end
  end

  assign irq_any = |(flags & ena);
endmodule

// File: rtl/irqt_regblk.sv
`timescale 1ns/1ps
module irqt_regblk #(
  parameter int DW = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cs,
  input  logic [irqt_pkg::REG_AW-1:0] addr,
  input  logic                       we,
  input  logic [DW-1:0]              wdata,
  input  logic                       rd,
  output logic [DW-1:0]              rdata,
  output logic                       irq
);
  import irqt_pkg::*;
  localparam int TW = 2*DW;
  localparam int FW = DW-1;

  ofs_e ofs;
  logic wr_stb, rd_stb;
  logic [DW-1:0] port_b, port_a, ddr_b, ddr_a, shf_q, aux_q, per_q;
  logic [TW-1:0] t1_count, t1_latch, t2_count, t2_latch;
  logic t1_expire, t2_expire, t1_ack, t2_ack;
  logic [FW-1:0] hw_set, flag_clr, flag_q, ena_q;

  assign ofs    = ofs_e'(addr);
  assign wr_stb = cs && we;
  assign rd_stb = cs && rd && !we;

  assign t1_ack = (wr_stb && ofs == OFS_T1CH) || (rd_stb && ofs == OFS_T1CL);
  assign t2_ack = (wr_stb && ofs == OFS_T2CH) || (rd_stb && ofs == OFS_T2CL);

  irqt_timer #(.DW(DW), .RELOAD_CAPABLE(1'b1)) u_timer1 (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_lo    (wr_stb && (ofs == OFS_T1CL || ofs == OFS_T1LL)),
    .wr_hi    (wr_stb && ofs == OFS_T1LH),
    .wr_start (wr_stb && ofs == OFS_T1CH),
    .wdata    (wdata),
    .free_run (aux_q[AUX_FREE]),
    .count    (t1_count),
    .latch    (t1_latch),
    .expire   (t1_expire)
  );

  irqt_timer #(.DW(DW), .RELOAD_CAPABLE(1'b0)) u_timer2 (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_lo    (wr_stb && ofs == OFS_T2CL),
    .wr_hi    (1'b0),
    .wr_start (wr_stb && ofs == OFS_T2CH),
    .wdata    (wdata),
    .free_run (1'b0),
    .count    (t2_count),
    .latch    (t2_latch),
    .expire   (t2_expire)
  );

  always_comb begin
    hw_set         = '0;
    hw_set[FLG_T1] = t1_expire;
    hw_set[FLG_T2] = t2_expire;
    flag_clr       = '0;
    if (wr_stb && ofs == OFS_FLG) flag_clr = wdata[FW-1:0];
    if (t1_ack) flag_clr[FLG_T1] = 1'b1;
    if (t2_ack) flag_clr[FLG_T2] = 1'b1;
  end

  irqt_irqctl #(.FW(FW)) u_irqctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_bits  (hw_set),
    .clr_bits  (flag_clr),
    .ena_wr    (wr_stb && ofs == OFS_ENA),
    .ena_wdata (wdata),
    .flags     (flag_q),
    .ena       (ena_q),
    .irq_any   (irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      port_b <= '0;
      port_a <= '0;
      ddr_b  <= '0;
      ddr_a  <= '0;
      shf_q  <= '0;
      aux_q  <= '0;
      per_q  <= '0;
    end else if (wr_stb) begin
      case (ofs)
        OFS_PB:          port_b <= wdata;
        OFS_PA, OFS_PA2: port_a <= wdata;
        OFS_DDRB:        ddr_b  <= wdata;
        OFS_DDRA:        ddr_a  <= wdata;
        OFS_SHF:         shf_q  <= wdata;
        OFS_AUX:         aux_q  <= wdata;
        OFS_PER:         per_q  <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (ofs)
      OFS_PB:          rdata = port_b;
      OFS_PA, OFS_PA2: rdata = port_a;
      OFS_DDRB:        rdata = ddr_b;
      OFS_DDRA:        rdata = ddr_a;
      OFS_T1CL:        rdata = t1_count[DW-1:0];
      OFS_T1CH:        rdata = t1_count[TW-1:DW];
      OFS_T1LL:        rdata = t1_latch[DW-1:0];
      OFS_T1LH:        rdata = t1_latch[TW-1:DW];
      OFS_T2CL:        rdata = t2_count[DW-1:0];
      OFS_T2CH:        rdata = t2_count[TW-1:DW];
      OFS_SHF:         rdata = shf_q;
      OFS_AUX:         rdata = aux_q;
      OFS_PER:         rdata = per_q;
      OFS_FLG:         rdata = {|(flag_q & ena_q), flag_q};
      OFS_ENA:         rdata = {1'b1, ena_q};
      default:         rdata = '0;
    endcase
  end

  logic unused_t2_latch;
  assign unused_t2_latch = ^t2_latch;
endmodule

// File: rtl/irqt_checker.sv
`timescale 1ns/1ps
module irqt_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs,
  input logic          we,
  input logic [3:0]    addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic          irq,
  input logic [2*DW-1:0] t1_count,
  input logic [2*DW-1:0] t1_latch,
  input logic [2*DW-1:0] t2_count,
  input logic          t1_expire,
  input logic [DW-2:0] flag_q,
  input logic [DW-2:0] ena_q
);
  localparam int TW = 2*DW;
  localparam logic [TW-1:0] ONE = {{(TW-1){1'b0}}, 1'b1};

  AST_T1_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && we && addr == 4'd5) |=> t1_count == {$past(wdata), $past(t1_latch[DW-1:0])}); // R4
  AST_T1_EXPIRE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    t1_expire |=> flag_q[6]); // R5
  AST_T2_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cs && we && addr == 4'd9) && t2_count != '0) |=> t2_count == $past(t2_count) - ONE); // R7
  AST_FLAG_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && we && addr == 4'd13 && wdata[6] && !t1_expire) |=> !flag_q[6]); // R8
  AST_ENA_READ_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 4'd14) |-> rdata[DW-1]); // R9
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_q == '0) |-> !irq); // R10
  AST_NO_CLEAR_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> (($past(flag_q) & ~flag_q) == '0)); // R11
endmodule

bind irqt_regblk irqt_checker #(.DW(DW)) u_irqt_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs        (cs),
  .we        (we),
  .addr      (addr),
  .wdata     (wdata),
  .rdata     (rdata),
  .irq       (irq),
  .t1_count  (t1_count),
  .t1_latch  (t1_latch),
  .t2_count  (t2_count),
  .t1_expire (t1_expire),
  .flag_q    (flag_q),
  .ena_q     (ena_q)
);

// File: tb/test_irqt_regblk.sv
`timescale 1ns/1ps
module test_irqt_regblk;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0;
  logic [3:0] addr = 4'd0;
  logic       we = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       rd = 1'b0;
  logic [7:0] rdata;
  logic       irq;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  irqt_regblk #(.DW(8)) i_irqt_regblk (
    .clk(clk), .rst_n(rst_n), .cs(cs), .addr(addr), .we(we),
    .wdata(wdata), .rd(rd), .rdata(rdata), .irq(irq)
  );

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    cs = 1'b1; we = 1'b1; rd = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [7:0] v);
    cs = 1'b0; rd = 1'b0; we = 1'b0; addr = a;
    #0.01;
    v = rdata;
  endtask

  task automatic rdstb(input logic [3:0] a, input logic sel);
    cs = sel; rd = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    cs = 1'b0; rd = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] regs [7];
    logic [7:0] pats [3];
    regs = '{8'd0, 8'd1, 8'd2, 8'd3, 8'd10, 8'd11, 8'd12};
    pats = '{8'hA5, 8'h1A, 8'h81};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset state
    foreach (regs[i]) if (regs[i] != 8'd10) begin
      peek(regs[i][3:0], v); chk("R2 reset register", v, 8'h00);
    end
    peek(4'd13, v); chk("R2 reset flags", v, 8'h00);
    peek(4'd14, v); chk("R2 reset enables", v, 8'h80);
    chk("R2 reset irq", {7'd0, irq}, 8'h00);

    // R1 plain registers and alias
    foreach (regs[i]) foreach (pats[j]) begin
      wr(regs[i][3:0], pats[j] ^ regs[i]);
      peek(regs[i][3:0], v); chk("R1 readback", v, pats[j] ^ regs[i]);
    end
    wr(4'd15, 8'h3C); peek(4'd1, v); chk("R1 alias 15->1", v, 8'h3C);
    wr(4'd1, 8'h96); peek(4'd15, v); chk("R1 alias 1->15", v, 8'h96);
    wr(4'd11, 8'h00);
    wr(4'd13, 8'h7F);

    // R9 enable set/clear sweep
    for (int p = 0; p < 128; p++) begin
      wr(4'd14, 8'h7F);
      wr(4'd14, 8'h80 | 8'(p));
      peek(4'd14, v); chk("R9 set enables", v, 8'h80 | 8'(p));
      wr(4'd14, 8'h55);
      peek(4'd14, v); chk("R9 clear enables", v, 8'h80 | (8'(p) & 8'h2A));
    end
    wr(4'd14, 8'h7F);

    // R3 / R4 latch and counter byte access
    wr(4'd4, 8'h34); wr(4'd5, 8'h12);
    peek(4'd4, v); chk("R4 counter low after load", v, 8'h34);
    peek(4'd5, v); chk("R4 counter high after load", v, 8'h12);
    peek(4'd6, v); chk("R3 latch low", v, 8'h34);
    peek(4'd7, v); chk("R3 latch high", v, 8'h12);
    wr(4'd7, 8'h56);
    peek(4'd5, v); chk("R3 offset 7 no load", v, 8'h12);
    peek(4'd4, v); chk("R3 counter still counting", v, 8'h33);
    peek(4'd7, v); chk("R3 latch high via 7", v, 8'h56);
    wr(4'd6, 8'h78);
    peek(4'd6, v); chk("R3 latch low via 6", v, 8'h78);
    peek(4'd4, v); chk("R3 offset 6 leaves counter", v, 8'h32);
    wr(4'd4, 8'h9A);
    peek(4'd6, v); chk("R3 latch low via 4", v, 8'h9A);
    peek(4'd4, v); chk("R3 offset 4 leaves counter", v, 8'h31);

    // R5 one-shot timer 1
    wr(4'd13, 8'h7F);
    for (int n = 0; n <= 6; n++) begin
      wr(4'd4, 8'(n)); wr(4'd5, 8'h00);
      for (int k = 0; k <= n; k++) begin
        peek(4'd13, v); chk("R5 no early flag", v & 8'h40, 8'h00);
        peek(4'd4, v); chk("R5 count down", v, 8'(n - k));
        @(negedge clk);
      end
      peek(4'd13, v); chk("R5 flag at underflow", v & 8'h40, 8'h40);
      peek(4'd5, v); chk("R5 wrap high", v, 8'hFF);
      peek(4'd4, v); chk("R5 wrap low", v, 8'hFF);
      repeat (4) @(negedge clk);
      peek(4'd13, v); chk("R5 flag held once", v & 8'h40, 8'h40);
      wr(4'd14, 8'hC0);
      peek(4'd13, v); chk("R8 summary bit set", v & 8'hC0, 8'hC0);
      #0.01; chk("R10 irq enabled", {7'd0, irq}, 8'h01);
      wr(4'd14, 8'h40);
      peek(4'd13, v); chk("R8 summary bit clear", v & 8'hC0, 8'h40);
      #0.01; chk("R10 irq masked", {7'd0, irq}, 8'h00);
      rdstb(4'd4, 1'b0);
      peek(4'd13, v); chk("R11 unselected read keeps flag", v & 8'h40, 8'h40);
      rdstb(4'd4, 1'b1);
      peek(4'd13, v); chk("R4 read offset 4 clears flag", v & 8'h40, 8'h00);
    end

    // R4 load clears a raised flag
    wr(4'd4, 8'h00); wr(4'd5, 8'h00);
    @(negedge clk);
    peek(4'd13, v); chk("R5 flag from zero start", v & 8'h40, 8'h40);
    wr(4'd5, 8'h20);
    peek(4'd13, v); chk("R4 write 5 clears flag", v & 8'h40, 8'h00);

    // R6 free-running timer 1
    wr(4'd11, 8'h40);
    for (int n = 1; n <= 4; n++) begin
      int start;
      start = 0;
      wr(4'd4, 8'(n)); wr(4'd5, 8'h00);
      for (int r = 0; r < 3; r++) begin
        for (int k = start; k <= n; k++) begin
          peek(4'd13, v); chk("R6 no early flag", v & 8'h40, 8'h00);
          peek(4'd4, v); chk("R6 count down", v, 8'(n - k));
          @(negedge clk);
        end
        peek(4'd13, v); chk("R6 flag each period", v & 8'h40, 8'h40);
        peek(4'd4, v); chk("R6 reload from latch", v, 8'(n));
        wr(4'd13, 8'h40);
        start = 1;
      end
    end
    wr(4'd11, 8'h00);

    // R7 timer 2
    for (int n = 0; n <= 5; n++) begin
      wr(4'd8, 8'(n)); wr(4'd9, 8'h00);
      for (int k = 0; k <= n; k++) begin
        peek(4'd13, v); chk("R7 no early flag", v & 8'h20, 8'h00);
        peek(4'd8, v); chk("R7 count down", v, 8'(n - k));
        @(negedge clk);
      end
      peek(4'd13, v); chk("R7 flag at underflow", v & 8'h20, 8'h20);
      peek(4'd9, v); chk("R7 wrap high", v, 8'hFF);
      peek(4'd8, v); chk("R7 wrap low", v, 8'hFF);
      repeat (3) @(negedge clk);
      peek(4'd13, v); chk("R7 flag held once", v & 8'h20, 8'h20);
      rdstb(4'd8, 1'b0);
      peek(4'd13, v); chk("R11 unselected read keeps flag", v & 8'h20, 8'h20);
      rdstb(4'd8, 1'b1);
      peek(4'd13, v); chk("R7 read offset 8 clears flag", v & 8'h20, 8'h00);
    end
    wr(4'd8, 8'h00); wr(4'd9, 8'h00);
    @(negedge clk);
    peek(4'd13, v); chk("R7 flag from zero start", v & 8'h20, 8'h20);
    wr(4'd9, 8'h10);
    peek(4'd13, v); chk("R7 write 9 clears flag", v & 8'h20, 8'h00);
    peek(4'd9, v); chk("R7 load high byte", v, 8'h10);

    // R10 / R8 irq against every enable pattern
    wr(4'd13, 8'h7F);
    wr(4'd4, 8'h01); wr(4'd5, 8'h00);
    wr(4'd8, 8'h01); wr(4'd9, 8'h00);
    repeat (5) @(negedge clk);
    peek(4'd13, v); chk("R8 both timer flags", v, 8'h60);
    for (int p = 0; p < 128; p++) begin
      logic any;
      any = (8'(p) & 8'h60) != 8'h00;
      wr(4'd14, 8'h7F);
      wr(4'd14, 8'h80 | 8'(p));
      peek(4'd13, v); chk("R8 flag read summary", v, any ? 8'hE0 : 8'h60);
      chk("R10 irq pattern", {7'd0, irq}, {7'd0, any});
    end
    wr(4'd13, 8'h20);
    peek(4'd13, v); chk("R8 write-one clears only bit 5", v & 8'h7F, 8'h40);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule